// File: doc/BRIEF.md
# OUT Endpoint Receive Gate

This block decides whether an OUT data packet arriving on a given endpoint may be written into the shared receive FIFO. Software runs it through a small register window. It first names an endpoint in a selection register. It then sets or clears that endpoint's arm flag, and finally raises a single global "go" flag. The arm flags together form a set of endpoints that are willing to receive. The go flag lets exactly one packet through from that set.

The packet side reports the start of each OUT transaction, with its endpoint number, and later reports its completion. At the start strobe the block latches its decision. The accept output then gates the FIFO write enable for the length of that transaction. When an accepted transaction completes, the go flag drops on its own. Arm flags on ordinary endpoints persist. The control endpoint also loses its arm flag, so software must re-arm it between the setup stage and any data stage. A pending output reports that go is set and at least one endpoint is armed.

Top module: `out_ep_gate`

## Requirements
- R1: After reset every arm flag, the go flag, the endpoint selection, pkt_accept and pending are all 0.
- R2: A write to address 1 sets the arm flag of the currently selected endpoint to wdata bit 0 and leaves every other endpoint's arm flag unchanged. The selection is written at address 0, bits 3:0.
- R3: A read of address 1 returns the selected endpoint's arm flag in bit 0 and zeros in bits 7:1, whatever was written to those bits.
- R4: pkt_accept is high from the cycle after pkt_start through the cycle of pkt_done only when, at the start strobe, the endpoint on pkt_ep was armed and go was set. Otherwise it stays low.
- R5: The completion of an accepted transaction clears go (address 2, bit 0). Arm flags of endpoints other than 0 stay set.
- R6: Only one packet is accepted per write of go. A second transaction after an accepted completion is refused until go is written to 1 again.
- R7: The completion of an accepted transaction on endpoint 0 clears endpoint 0's arm flag.
- R8: The completion of a transaction that was refused leaves go set.
- R9: A software write to go in the same cycle as an accepted completion takes priority, and go takes the written value.
- R10: pending is high exactly when go is set and at least one endpoint is armed.
- R11: A read of address 0 returns the selected endpoint number in bits 3:0 with zeros above. A read of address 2 returns go in bit 0. A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address: 0 select, 1 arm, 2 go |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, combinational on cpu_addr |
| pkt_start | input | 1 | OUT transaction start strobe |
| pkt_ep | input | 4 | Endpoint of the starting transaction |
| pkt_done | input | 1 | Transaction completion strobe |
| pkt_accept | output | 1 | FIFO write gate for the current transaction |
| pending | output | 1 | Go set and at least one endpoint armed |

## Verification
The bound checker watches the per-cycle rules on every cycle. These are: a refused start never raises accept; an accepted completion drops go unless software writes it at the same moment; a colliding software write decides go; endpoint 0 is disarmed after its accepted packet; and the arm set moves only under a software write or a control completion. Some behaviours need a sequence of transactions, and only the bench's scenarios can show them. These are the one-packet-per-go rule over two packets, go surviving a refused transaction, ordinary endpoints keeping their arm flags across packets, and the reserved bits reading as zero.

// File: rtl/out_ep_gate_pkg.sv
package out_ep_gate_pkg;

  typedef enum logic [1:0] {
    RA_SELECT = 2'd0,
    RA_ARM    = 2'd1,
    RA_GO     = 2'd2,
    RA_SPARE  = 2'd3
  } reg_addr_e;

  // A transaction may enter the FIFO only if its endpoint is armed and go is set.
  function automatic logic gate_open(input logic armed, input logic go);
    return armed & go;
  endfunction

  // Next go value: a software write wins, else an accepted completion clears it.
  function automatic logic next_go(input logic cur, input logic sw_wr,
                                   input logic sw_val, input logic done_ok);
    if (sw_wr)        return sw_val;
    else if (done_ok) return 1'b0;
    else              return cur;
  endfunction

endpackage

// File: rtl/oeg_regs.sv
module oeg_regs
  import out_ep_gate_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int DATA_W = 8,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [NUM_EP-1:0] arm_vec,
  input  logic              go,
  output logic [EP_W-1:0]   sel,
  output logic              arm_wr,
  output logic              go_wr,
  output logic              wbit,
  output logic [DATA_W-1:0] cpu_rdata
);

  reg_addr_e addr;
  logic      unused_wbits;

  assign addr         = reg_addr_e'(cpu_addr);
  assign arm_wr       = cpu_wr && (addr == RA_ARM);
  assign go_wr        = cpu_wr && (addr == RA_GO);
  assign wbit         = cpu_wdata[0];
  assign unused_wbits = ^cpu_wdata[DATA_W-1:EP_W];

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel <= '0;
    else if (cpu_wr && addr == RA_SELECT)
      sel <= cpu_wdata[EP_W-1:0];
  end

  always_comb begin
    unique case (addr)
      RA_SELECT: cpu_rdata = DATA_W'(sel);
      RA_ARM:    cpu_rdata = DATA_W'(arm_vec[sel]);
      RA_GO:     cpu_rdata = DATA_W'(go);
      default:   cpu_rdata = '0;
    endcase
  end

endmodule

// File: rtl/oeg_arm_map.sv
module oeg_arm_map #(
  parameter int NUM_EP  = 16,
  parameter int CTRL_EP = 0,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_wr,
  input  logic [EP_W-1:0]   sel,
  input  logic              wbit,
  input  logic              done_ok,
  input  logic [EP_W-1:0]   done_ep,
  output logic [NUM_EP-1:0] arm_vec
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hit_sw;
    assign hit_sw = arm_wr && (sel == EP_W'(i));

    if (i == CTRL_EP) begin : g_ctrl
      // Control endpoint: disarmed after each accepted packet, software write wins.
      logic hit_done;
      assign hit_done = done_ok && (done_ep == EP_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n)        arm_vec[i] <= 1'b0;
        else if (hit_sw)   arm_vec[i] <= wbit;
        else if (hit_done) arm_vec[i] <= 1'b0;
      end
    end else begin : g_data
      // Ordinary endpoint: arm flag is sticky.
      always_ff @(posedge clk) begin
        if (!rst_n)      arm_vec[i] <= 1'b0;
        else if (hit_sw) arm_vec[i] <= wbit;
      end
    end
  end

endmodule

// File: rtl/oeg_xfer.sv
module oeg_xfer
  import out_ep_gate_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pkt_start,
  input  logic [EP_W-1:0] pkt_ep,
  input  logic            pkt_done,
  input  logic            start_armed,
  input  logic            go_wr,
  input  logic            wbit,
  output logic            go,
  output logic            accept,
  output logic            done_ok,
  output logic [EP_W-1:0] done_ep
);

  logic            busy;
  logic            granted;
  logic [EP_W-1:0] cur_ep;

  assign done_ok = pkt_done && busy && granted;
  assign done_ep = cur_ep;
  assign accept  = busy && granted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      granted <= 1'b0;
      cur_ep  <= '0;
    end else if (pkt_start) begin
      busy    <= 1'b1;
      granted <= gate_open(start_armed, go);
      cur_ep  <= pkt_ep;
    end else if (pkt_done) begin
      busy    <= 1'b0;
      granted <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) go <= 1'b0;
    else        go <= next_go(go, go_wr, wbit, done_ok);
  end

endmodule

// File: rtl/out_ep_gate.sv
module out_ep_gate
  import out_ep_gate_pkg::*;
#(
  parameter int NUM_EP  = 16,
  parameter int DATA_W  = 8,
  parameter int CTRL_EP = 0,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              pkt_start,
  input  logic [EP_W-1:0]   pkt_ep,
  input  logic              pkt_done,
  output logic              pkt_accept,
  output logic              pending
);

  logic [NUM_EP-1:0] arm_vec;
  logic [EP_W-1:0]   sel;
  logic              arm_wr;
  logic              go_wr;
  logic              wbit;
  logic              go;
  logic              done_ok;
  logic [EP_W-1:0]   done_ep;
  logic              start_armed;

  assign start_armed = arm_vec[pkt_ep];
  assign pending     = go && (|arm_vec);

  oeg_regs #(.NUM_EP(NUM_EP), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .arm_vec(arm_vec), .go(go), .sel(sel),
    .arm_wr(arm_wr), .go_wr(go_wr), .wbit(wbit), .cpu_rdata(cpu_rdata)
  );

  oeg_arm_map #(.NUM_EP(NUM_EP), .CTRL_EP(CTRL_EP)) u_arm (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .sel(sel), .wbit(wbit),
    .done_ok(done_ok), .done_ep(done_ep), .arm_vec(arm_vec)
  );

  oeg_xfer #(.NUM_EP(NUM_EP)) u_xfer (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_ep(pkt_ep),
    .pkt_done(pkt_done), .start_armed(start_armed), .go_wr(go_wr),
    .wbit(wbit), .go(go), .accept(pkt_accept), .done_ok(done_ok),
    .done_ep(done_ep)
  );

endmodule

// File: rtl/out_ep_gate_chk.sv
module out_ep_gate_chk #(
  parameter int NUM_EP  = 16,
  parameter int CTRL_EP = 0,
  localparam int EP_W = $clog2(NUM_EP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_start,
  input logic [EP_W-1:0]   pkt_ep,
  input logic              pkt_accept,
  input logic              go,
  input logic [NUM_EP-1:0] arm_vec,
  input logic              arm_wr,
  input logic              go_wr,
  input logic              wbit,
  input logic [EP_W-1:0]   sel,
  input logic              done_ok,
  input logic [EP_W-1:0]   done_ep
);

  a_r4_refused_start: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start && !(arm_vec[pkt_ep] && go) |=> !pkt_accept);

  a_r4_granted_start: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start && arm_vec[pkt_ep] && go |=> pkt_accept);

  a_r5_done_drops_go: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok && !go_wr |=> !go);

  a_r9_sw_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr |=> go == $past(wbit));

  a_r6_go_holds: assert property (@(posedge clk) disable iff (!rst_n)
    go && !go_wr && !done_ok |=> go);

  a_r7_ctrl_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok && done_ep == EP_W'(CTRL_EP) && !(arm_wr && sel == EP_W'(CTRL_EP))
    |=> !arm_vec[CTRL_EP]);

  a_r2_arm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_wr && !done_ok |=> $stable(arm_vec));

  a_r2_arm_write: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> arm_vec[$past(sel)] == $past(wbit));

endmodule

bind out_ep_gate out_ep_gate_chk #(.NUM_EP(NUM_EP), .CTRL_EP(CTRL_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_ep(pkt_ep),
  .pkt_accept(pkt_accept), .go(go), .arm_vec(arm_vec), .arm_wr(arm_wr),
  .go_wr(go_wr), .wbit(wbit), .sel(sel), .done_ok(done_ok), .done_ep(done_ep)
);

// File: tb/out_ep_gate_test.sv
module out_ep_gate_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       pkt_start = 1'b0;
  logic [3:0] pkt_ep = 4'd0;
  logic       pkt_done = 1'b0;
  logic       pkt_accept;
  logic       pending;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  out_ep_gate uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pkt_start(pkt_start),
    .pkt_ep(pkt_ep), .pkt_done(pkt_done), .pkt_accept(pkt_accept),
    .pending(pending)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic arm(input int ep, input logic v);
    wr(2'd0, 8'(ep));
    wr(2'd1, {7'd0, v});
  endtask

  task automatic pkt_begin(input int ep);
    @(negedge clk);
    pkt_start = 1'b1; pkt_ep = 4'(ep);
    @(posedge clk);
    @(negedge clk);
    pkt_start = 1'b0;
  endtask

  task automatic pkt_end();
    pkt_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R1 accept", pkt_accept, 0);
    chk("R1 pending", pending, 0);
    rd(2'd0, d); chk("R1 select", d, 0);
    rd(2'd2, d); chk("R1 go", d, 0);
    for (int e = 0; e < 16; e++) begin
      wr(2'd0, 8'(e));
      rd(2'd1, d); chk("R1 arm", d, 0);
    end
  endtask

  task automatic t_arm_select();
    logic [7:0] d;
    do_reset();
    arm(5, 1'b1);
    rd(2'd0, d); chk("R11 select readback", d, 5);
    wr(2'd0, 8'hF9);
    rd(2'd0, d); chk("R11 select upper zero", d, 9);
    rd(2'd1, d); chk("R2 other ep unarmed", d, 0);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R3 reserved bits zero", d, 1);
    wr(2'd0, 8'd5);
    rd(2'd1, d); chk("R2 ep5 still armed", d, 1);
    wr(2'd1, 8'hFE);
    rd(2'd1, d); chk("R2 ep5 disarmed", d, 0);
    wr(2'd0, 8'd9);
    rd(2'd1, d); chk("R2 ep9 unaffected", d, 1);
    rd(2'd3, d); chk("R11 spare reads zero", d, 0);
  endtask

  task automatic t_accept_rules();
    logic [7:0] d;
    do_reset();
    arm(3, 1'b1);
    pkt_begin(3);
    chk("R4 no go refused", pkt_accept, 0);
    pkt_end();
    wr(2'd2, 8'd1);
    rd(2'd2, d); chk("R11 go readback", d, 1);
    pkt_begin(4);
    chk("R4 unarmed ep refused", pkt_accept, 0);
    pkt_end();
    rd(2'd2, d); chk("R8 refused keeps go", d, 1);
    pkt_begin(3);
    chk("R4 armed ep accepted", pkt_accept, 1);
    @(negedge clk);
    chk("R4 accept held", pkt_accept, 1);
    pkt_done = 1'b1;
    #1 chk("R4 accept in done cycle", pkt_accept, 1);
    @(posedge clk);
    @(negedge clk);
    pkt_done = 1'b0;
    chk("R4 accept drops after done", pkt_accept, 0);
    rd(2'd2, d); chk("R5 go cleared", d, 0);
    wr(2'd0, 8'd3);
    rd(2'd1, d); chk("R5 ep3 stays armed", d, 1);
  endtask

  task automatic t_one_shot();
    do_reset();
    arm(7, 1'b1);
    wr(2'd2, 8'd1);
    pkt_begin(7); chk("R6 first accepted", pkt_accept, 1); pkt_end();
    pkt_begin(7); chk("R6 second refused", pkt_accept, 0); pkt_end();
    wr(2'd2, 8'd1);
    pkt_begin(7); chk("R6 re-go accepted", pkt_accept, 1); pkt_end();
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    do_reset();
    arm(0, 1'b1);
    wr(2'd2, 8'd1);
    pkt_begin(0); chk("R7 ctrl accepted", pkt_accept, 1); pkt_end();
    wr(2'd0, 8'd0);
    rd(2'd1, d); chk("R7 ctrl disarmed", d, 0);
    wr(2'd2, 8'd1);
    pkt_begin(0); chk("R7 ctrl refused until rearmed", pkt_accept, 0); pkt_end();
    rd(2'd2, d); chk("R8 go kept after refusal", d, 1);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    do_reset();
    arm(2, 1'b1);
    wr(2'd2, 8'd1);
    pkt_begin(2);
    chk("R9 setup accepted", pkt_accept, 1);
    pkt_done = 1'b1;
    cpu_wr = 1'b1; cpu_addr = 2'd2; cpu_wdata = 8'd1;
    @(posedge clk);
    @(negedge clk);
    pkt_done = 1'b0; cpu_wr = 1'b0;
    rd(2'd2, d); chk("R9 sw write wins", d, 1);
    pkt_begin(2); chk("R9 next packet accepted", pkt_accept, 1); pkt_end();
  endtask

  task automatic t_pending();
    do_reset();
    wr(2'd2, 8'd1);
    chk("R10 go without arm", pending, 0);
    arm(12, 1'b1);
    chk("R10 go and arm", pending, 1);
    wr(2'd2, 8'd0);
    chk("R10 arm without go", pending, 0);
    wr(2'd2, 8'd1);
    pkt_begin(12); pkt_end();
    chk("R10 after accepted packet", pending, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_arm_select();
    t_accept_rules();
    t_one_shot();
    t_ctrl();
    t_collision();
    t_pending();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule